// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block keeps a calendar date as a four-digit BCD year, a two-digit BCD month and a two-digit BCD day. A single-cycle day-advance strobe, normally driven once per day by a time-of-day counter, moves the date forward by one day. It takes account of 28, 29, 30 and 31 day months, of the Gregorian leap-year rules, and of the year rollover.

Software reaches the date through one bus register with no address lines. A write replaces the day, month and year fields of that register. A field written as all ones keeps its current value, so one field can be changed on its own. A read returns the packed date. Every access is acknowledged exactly one cycle after it is presented, and the stall output never rises.

Top module: `cal_date_top`

## Requirements
- R1: After reset the register holds year 2000, month 01, day 01, and acknowledge is low.
- R2: The read word carries the BCD day in bits 5:0, the BCD month in bits 12:8 and the BCD year in bits 29:16. Bits 7:6, 15:13 and 31:30 always read as zero, whatever was written to them.
- R3: Acknowledge is high in the cycle after any cycle with cycle and strobe both high, for reads and writes alike, and low otherwise. Stall is always low.
- R4: An access with cycle, strobe and write-enable high loads the day, month and year from the matching bits of the write data, and the new value reads back in the next cycle.
- R5: A write field that is all ones (day 6'h3F, month 5'h1F, year 14'h3FFF) leaves that field unchanged while the other fields are written.
- R6: A day-advance pulse below the month's last day increments the BCD day by one, with a decimal carry from 09 to 10 and from 19 to 20.
- R7: Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30. Advancing from the last day, or from any later day, sets the day to 01 and increments the BCD month (09 goes to 10).
- R8: February has 29 days when the year is divisible by 4 and not by 100, or when it is divisible by 400, and 28 days otherwise.
- R9: Advancing from December 31 gives January 01 of the next BCD year, with decimal carries through all four digits. Year 3999 wraps to 0000.
- R10: When a write and a day-advance pulse arrive in the same cycle, the write is applied and the advance is dropped.
- R11: A write-enable access without both cycle and strobe, and any read, leave the date unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dayPulse | input | 1 | One-cycle day-advance strobe |
| busCyc | input | 1 | Bus cycle active |
| busStb | input | 1 | Bus strobe |
| busWe | input | 1 | Bus write enable |
| busWrData | input | 32 | Write data, packed date |
| busAck | output | 1 | Acknowledge, one cycle after cycle and strobe |
| busStall | output | 1 | Stall, held low |
| busRdData | output | 32 | Read data, packed date |

## Verification
The range and length assertions assume that every write holds a valid BCD date: day between 01 and the month length, month between 01 and 12, year digits 0 to 9 with the top digit no greater than 3, and each field either valid or all ones. The stimulus writes only dates built from integer year, month and day values through a BCD encoder, or all-ones keep patterns. The day-advance strobe is pulsed only after a valid date has been loaded, so the ranges stay valid across long walks of several years each. The walks cross the 1900, 2000 and 2100 century years and the 3999 wrap.

// File: rtl/cal_date_pkg.sv
package cal_date_pkg;

  localparam int BUS_W       = 32;
  localparam int DAY_W       = 6;
  localparam int MON_W       = 5;
  localparam int YEAR_W      = 14;
  localparam int DAY_LSB     = 0;
  localparam int MON_LSB     = 8;
  localparam int YEAR_LSB    = 16;
  localparam int YEAR_DIGITS = 4;
  localparam int YEAR_PAD_W  = YEAR_DIGITS * 4;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
  } date_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic keepDay;
    logic keepMonth;
    logic keepYear;
    logic advance;
  } dateCtl_t;

  // two BCD digits form a number divisible by four
  function automatic logic div4Pair(input logic [3:0] tens, input logic [3:0] units);
    if (!tens[0]) return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
    else          return (units == 4'd2) || (units == 4'd6);
  endfunction

  function automatic logic isLeapYear(input logic [YEAR_W-1:0] yr);
    logic [YEAR_PAD_W-1:0] y;
    y = YEAR_PAD_W'(yr);
    if (y[7:0] == 8'h00) return div4Pair(y[15:12], y[11:8]);
    else                 return div4Pair(y[7:4], y[3:0]);
  endfunction

  function automatic logic [DAY_W-1:0] monthLength(input logic [MON_W-1:0] mon,
                                                   input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc2(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/cal_date_ctrl.sv
module cal_date_ctrl
  import cal_date_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dayPulse,
  input  logic             busCyc,
  input  logic             busStb,
  input  logic             busWe,
  input  logic [BUS_W-1:0] busWrData,
  output dateCtl_t         ctl,
  output date_t            wrFields,
  output logic             busAck
);

  logic access;
  logic ackQ;

  assign access = busCyc && busStb;

  always_comb begin
    wrFields.day   = busWrData[DAY_LSB  +: DAY_W];
    wrFields.month = busWrData[MON_LSB  +: MON_W];
    wrFields.year  = busWrData[YEAR_LSB +: YEAR_W];
    ctl.load       = access && busWe;
    ctl.keepDay    = &wrFields.day;
    ctl.keepMonth  = &wrFields.month;
    ctl.keepYear   = &wrFields.year;
    ctl.advance    = dayPulse && !(access && busWe);
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= access;
  end

  assign busAck = ackQ;

  // R3: acknowledge follows an access by one cycle
  a_r3_ack_after_access: assert property (@(posedge clk) disable iff (!rstN)
    access |=> busAck);
  a_r3_no_spurious_ack: assert property (@(posedge clk) disable iff (!rstN)
    !access |=> !busAck);

endmodule

// File: rtl/cal_date_dp.sv
module cal_date_dp
  import cal_date_pkg::*;
#(
  parameter logic [YEAR_W-1:0] RESET_YEAR  = 14'h2000,
  parameter logic [MON_W-1:0]  RESET_MONTH = 5'h01,
  parameter logic [DAY_W-1:0]  RESET_DAY   = 6'h01
) (
  input  logic     clk,
  input  logic     rstN,
  input  dateCtl_t ctl,
  input  date_t    wrFields,
  output date_t    dateQ
);

  logic                  leap;
  logic [DAY_W-1:0]      lastDay;
  logic                  atEnd;
  logic                  yearEnd;
  logic [YEAR_PAD_W-1:0] yPad;
  logic [YEAR_PAD_W-1:0] yNext;
  logic [YEAR_DIGITS:0]  carry;
  logic [7:0]            dayInc;
  logic [7:0]            monInc;
  date_t                 dateD;

  assign leap    = isLeapYear(dateQ.year);
  assign lastDay = monthLength(dateQ.month, leap);
  assign atEnd   = dateQ.day >= lastDay;
  assign yearEnd = dateQ.month >= 5'h12;
  assign dayInc  = bcdInc2(8'(dateQ.day));
  assign monInc  = bcdInc2(8'(dateQ.month));

  // year increment: decimal ripple carry through the BCD digits
  assign yPad     = YEAR_PAD_W'(dateQ.year);
  assign carry[0] = 1'b1;
  for (genvar g = 0; g < YEAR_DIGITS; g++) begin : gYearDigit
    logic [3:0] digit;
    assign digit              = yPad[g*4 +: 4];
    assign carry[g+1]         = carry[g] && (digit == 4'd9);
    assign yNext[g*4 +: 4]    = !carry[g] ? digit :
                                (digit == 4'd9) ? 4'd0 : digit + 4'd1;
  end

  always_comb begin
    dateD = dateQ;
    if (ctl.load) begin
      if (!ctl.keepDay)   dateD.day   = wrFields.day;
      if (!ctl.keepMonth) dateD.month = wrFields.month;
      if (!ctl.keepYear)  dateD.year  = wrFields.year;
    end else if (ctl.advance) begin
      if (atEnd) begin
        dateD.day = 6'h01;
        if (yearEnd) begin
          dateD.month = 5'h01;
          dateD.year  = yNext[YEAR_W-1:0];
        end else begin
          dateD.month = monInc[MON_W-1:0];
        end
      end else begin
        dateD.day = dayInc[DAY_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dateQ.year  <= RESET_YEAR;
      dateQ.month <= RESET_MONTH;
      dateQ.day   <= RESET_DAY;
    end else begin
      dateQ <= dateD;
    end
  end

  // R6: an advance always changes the date
  a_r6_advance_moves: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (dateQ != $past(dateQ)));
  // R11: without load or advance the date holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.advance) |=> $stable(dateQ));
  // R7: month end inside the year keeps the year and restarts the day
  a_r7_month_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && atEnd && !yearEnd) |=>
      (dateQ.day == 6'h01 && dateQ.year == $past(dateQ.year)));
  // R7: day and month never read zero given valid writes
  a_r7_fields_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (dateQ.day != '0 && dateQ.month != '0));
  // R8: leap February reaches its 29th
  a_r8_leap_feb: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && dateQ.month == 5'h02 && dateQ.day == 6'h28 && leap) |=>
      (dateQ.day == 6'h29));
  // R9: year end restarts at January 01
  a_r9_year_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && atEnd && yearEnd) |=>
      (dateQ.month == 5'h01 && dateQ.day == 6'h01));

endmodule

// File: rtl/cal_date_top.sv
module cal_date_top
  import cal_date_pkg::*;
#(
  parameter logic [YEAR_W-1:0] RESET_YEAR  = 14'h2000,
  parameter logic [MON_W-1:0]  RESET_MONTH = 5'h01,
  parameter logic [DAY_W-1:0]  RESET_DAY   = 6'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dayPulse,
  input  logic             busCyc,
  input  logic             busStb,
  input  logic             busWe,
  input  logic [BUS_W-1:0] busWrData,
  output logic             busAck,
  output logic             busStall,
  output logic [BUS_W-1:0] busRdData
);

  dateCtl_t ctl;
  date_t    wrFields;
  date_t    dateQ;

  cal_date_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .dayPulse  (dayPulse),
    .busCyc    (busCyc),
    .busStb    (busStb),
    .busWe     (busWe),
    .busWrData (busWrData),
    .ctl       (ctl),
    .wrFields  (wrFields),
    .busAck    (busAck)
  );

  cal_date_dp #(
    .RESET_YEAR  (RESET_YEAR),
    .RESET_MONTH (RESET_MONTH),
    .RESET_DAY   (RESET_DAY)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrFields (wrFields),
    .dateQ    (dateQ)
  );

  // R2: packed read word, unused bits zero
  always_comb begin
    busRdData                          = '0;
    busRdData[DAY_LSB  +: DAY_W]       = dateQ.day;
    busRdData[MON_LSB  +: MON_W]       = dateQ.month;
    busRdData[YEAR_LSB +: YEAR_W]      = dateQ.year;
  end

  assign busStall = 1'b0;

endmodule

// File: tb/cal_date_top_tb_top.sv
module cal_date_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dayPulse = 1'b0;
  logic        busCyc = 1'b0;
  logic        busStb = 1'b0;
  logic        busWe = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busAck;
  logic        busStall;
  logic [31:0] busRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int my, mm, md;  // bench model of the date

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_date_top dut_i (
    .clk(clk), .rstN(rstN), .dayPulse(dayPulse),
    .busCyc(busCyc), .busStb(busStb), .busWe(busWe), .busWrData(busWrData),
    .busAck(busAck), .busStall(busStall), .busRdData(busRdData)
  );

  function automatic int bcd4(int v);
    return (((v/1000)%10) << 12) | (((v/100)%10) << 8) | (((v/10)%10) << 4) | (v%10);
  endfunction

  function automatic logic [31:0] packDate(int y, int m, int d);
    return 32'((bcd4(y) << 16) | (bcd4(m) << 8) | bcd4(d));
  endfunction

  function automatic bit leapOf(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int daysIn(int y, int m);
    if (m == 2) return leapOf(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busAccess(bit we, logic [31:0] data, bit withPulse);
    @(negedge clk);
    busCyc = 1'b1; busStb = 1'b1; busWe = we; busWrData = data; dayPulse = withPulse;
    check("R3", {31'b0, busStall}, 32'h0);
    @(negedge clk);
    busCyc = 1'b0; busStb = 1'b0; busWe = 1'b0; dayPulse = 1'b0;
    check("R3", {31'b0, busAck}, 32'h1);
  endtask

  task automatic setDate(int y, int m, int d);
    my = y; mm = m; md = d;
    busAccess(1'b1, packDate(y, m, d), 1'b0);
    check("R4", busRdData, packDate(y, m, d));
  endtask

  task automatic walk(int y, int m, int d, int n);
    setDate(y, m, d);
    for (int i = 0; i < n; i++) begin
      string tag;
      if (md >= daysIn(my, mm)) tag = (mm == 12) ? "R9" : "R7";
      else if (mm == 2 && md >= 28) tag = "R8";
      else tag = "R6";
      if (md >= daysIn(my, mm)) begin
        md = 1;
        if (mm == 12) begin mm = 1; my = (my + 1) % 4000; end
        else mm++;
      end else md++;
      @(negedge clk); dayPulse = 1'b1;
      @(negedge clk); dayPulse = 1'b0;
      check(tag, busRdData, packDate(my, mm, md));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", busRdData, packDate(2000, 1, 1));
    check("R1", {31'b0, busAck}, 32'h0);
    check("R3", {31'b0, busStall}, 32'h0);

    // R2: reserved bits ignored on write, zero on read
    busAccess(1'b1, packDate(1234, 5, 6) | 32'hC000_E0C0, 1'b0);
    check("R2", busRdData, packDate(1234, 5, 6));

    // R5: keep patterns per field
    setDate(2000, 1, 1);
    busAccess(1'b1, {2'b0, 14'h3FFF, 3'b0, 5'h07, 2'b0, 6'h15}, 1'b0);
    check("R5", busRdData, packDate(2000, 7, 15));
    busAccess(1'b1, {2'b0, 14'h2024, 3'b0, 5'h1F, 2'b0, 6'h09}, 1'b0);
    check("R5", busRdData, packDate(2024, 7, 9));
    busAccess(1'b1, {2'b0, 14'h1987, 3'b0, 5'h03, 2'b0, 6'h3F}, 1'b0);
    check("R5", busRdData, packDate(1987, 3, 9));
    busAccess(1'b1, {2'b0, 14'h3FFF, 3'b0, 5'h1F, 2'b0, 6'h3F}, 1'b0);
    check("R5", busRdData, packDate(1987, 3, 9));

    // R11: incomplete accesses and reads leave the date alone
    @(negedge clk);
    busCyc = 1'b1; busStb = 1'b0; busWe = 1'b1; busWrData = packDate(1111, 1, 1);
    @(negedge clk);
    busCyc = 1'b0; busStb = 1'b1;
    @(negedge clk);
    busStb = 1'b0; busWe = 1'b0;
    check("R11", busRdData, packDate(1987, 3, 9));
    check("R3", {31'b0, busAck}, 32'h0);
    busAccess(1'b0, packDate(1111, 1, 1), 1'b0);
    check("R11", busRdData, packDate(1987, 3, 9));

    // R10: write beats a same-cycle advance
    busAccess(1'b1, packDate(2001, 2, 28), 1'b1);
    check("R10", busRdData, packDate(2001, 2, 28));
    busAccess(1'b1, {2'b0, 14'h3FFF, 3'b0, 5'h1F, 2'b0, 6'h3F}, 1'b1);
    check("R10", busRdData, packDate(2001, 2, 28));

    // R7: day beyond month end also wraps
    setDate(2001, 4, 31);
    @(negedge clk); dayPulse = 1'b1;
    @(negedge clk); dayPulse = 1'b0;
    check("R7", busRdData, packDate(2001, 5, 1));

    // sweeps: R6 R7 R8 R9 across century years and the top wrap
    walk(1899, 1, 1, 800);
    walk(1999, 11, 1, 800);
    walk(2095, 2, 1, 1900);
    walk(3999, 12, 30, 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule